// File: doc/BRIEF.md
# UART Interrupt Priority and Identification Unit

This unit merges the interrupt sources of a 16550-class serial port into one registered interrupt line and an 8-bit identification value. Each clock it looks at the enable register it holds and at the status flags that the receive and transmit datapaths supply. These flags are the line error bits, data-ready, the receive FIFO fill level against its trigger level, the character-timeout flag and the modem-status change bits. From them it selects the single highest-priority pending cause.

The unit also holds the transmit-holding-empty pending flag and the two transmitter status bits (holding register empty, transmitter empty). That flag is set when the transmitter drains the holding register. It is cleared when software writes a character, or when software reads the identification value while that value reports the holding-empty cause. Toggling the holding-empty enable re-arms the flag from the current holding-empty status. The FIFO storage, the shift registers and the baud clock sit outside the unit and reach it only through its status inputs and event strobes.

Top module: `uirq_ctrl`

## Requirements
- R1: After reset, iir_o is 0x01, irq_o is 0, ier_o is 0x00, lsr_thre_o is 1, lsr_temt_o is 1 and the holding-empty flag is clear.
- R2: When ier bit 2 is set and any bit of lsr_err is set (bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break), iir_o[3:0] is 0x6. This cause outranks all others.
- R3: When ier bit 0 is set and timeout_pend is 1, and no line-error cause applies, iir_o[3:0] is 0xC. There is no separate enable for this cause, so clearing ier bit 0 masks it.
- R4: When ier bit 0 is set and data_ready is 1, iir_o[3:0] is 0x4, provided that no higher cause applies and that either fifo_en is 0 or rx_count is at least rx_trig. Data-ready with rx_count below rx_trig raises nothing while fifo_en is 1.
- R5: When ier bit 1 is set and the holding-empty flag is set, and no higher cause applies, iir_o[3:0] is 0x2.
- R6: When ier bit 3 is set and any bit of msr_delta is set, and no higher cause applies, iir_o[3:0] is 0x0. With no cause at all, iir_o[3:0] is 0x1.
- R7: iir_o[7:6] is 2'b11 while fifo_en is 1 and 2'b00 otherwise, and iir_o[5:4] is always 0.
- R8: iir_o and irq_o are registered from the same inputs. irq_o is 1 exactly when iir_o[0] is 0, and both change one clock after their inputs.
- R9: A pulse on iir_rd while iir_o[3:0] is 0x2 clears the holding-empty flag. A pulse on iir_rd while another code is shown leaves the flag unchanged.
- R10: An ier_wr that changes ier bit 1 sets the holding-empty flag if the new bit 1 is 1 and lsr_thre_o is 1, and clears it otherwise. An ier_wr that keeps bit 1 unchanged leaves the flag alone.
- R11: A pulse on thr_wr clears the holding-empty flag, lsr_thre_o and lsr_temt_o.
- R12: ier_wr stores ier_wdata[3:0]. ier_o[7:4] always reads 0.
- R13: A pulse on tx_empty_evt sets lsr_thre_o and the holding-empty flag. A pulse on tx_idle_evt sets lsr_temt_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| iir_rd | input | 1 | Identification read strobe |
| thr_wr | input | 1 | Holding register write strobe |
| tx_empty_evt | input | 1 | Transmitter drained the holding register |
| tx_idle_evt | input | 1 | Transmitter shifter went idle |
| fifo_en | input | 1 | FIFO mode enabled |
| lsr_err | input | 4 | Overrun, parity, framing, break flags (bits 0..3) |
| data_ready | input | 1 | Receive data available |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_trig | input | CNT_W | Receive FIFO trigger level |
| timeout_pend | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem status change bits |
| ier_o | output | 8 | Enable register read value |
| iir_o | output | 8 | Identification value |
| irq_o | output | 1 | Interrupt request |
| lsr_thre_o | output | 1 | Holding register empty status |
| lsr_temt_o | output | 1 | Transmitter empty status |

## Verification
The bench builds the unit with FIFO_DEPTH of 16 and the FIFO-compare variant selected, which makes the count inputs five bits wide. That width lets the bench place the fill level just below and exactly at a trigger level. It can also step through every cause in turn, stacking higher causes on lower ones to show the priority order, with FIFO mode both on and off. The holding-empty flag is exercised through each of its set and clear paths, including enable toggles while the holding register is full and empty.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
   typedef enum logic [3:0] {
      IID_MODEM   = 4'h0,
      IID_NONE    = 4'h1,
      IID_THRE    = 4'h2,
      IID_RXDATA  = 4'h4,
      IID_LINE    = 4'h6,
      IID_TIMEOUT = 4'hC
   } iid_e;

   localparam int NUM_SRC = 5;

   // index 0 is the highest priority
   function automatic iid_e src_code(input int idx);
      case (idx)
         0:       return IID_LINE;
         1:       return IID_TIMEOUT;
         2:       return IID_RXDATA;
         3:       return IID_THRE;
         default: return IID_MODEM;
      endcase
   endfunction
endpackage

// File: rtl/uirq_ier_reg.sv
module uirq_ier_reg #(
   parameter int BUS_W    = 8,
   parameter int IER_BITS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [BUS_W-1:0]    wdata,
   output logic [IER_BITS-1:0] ier_q,
   output logic                thri_flip
);
   generate
      if (IER_BITS < 4 || IER_BITS >= BUS_W) begin : g_bad_width
         $error("uirq_ier_reg: IER_BITS must be in 4..BUS_W-1");
      end
   endgenerate

   logic unused_hi_bits;
   assign unused_hi_bits = ^wdata[BUS_W-1:IER_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ier_q <= '0;
      else if (wr) ier_q <= wdata[IER_BITS-1:0];
   end

   assign thri_flip = wr && (wdata[1] != ier_q[1]);

   // R12
   ier_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> ier_q == $past(wdata[IER_BITS-1:0]));
endmodule

// File: rtl/uirq_thre_track.sv
module uirq_thre_track (
   input  logic clk,
   input  logic rst_n,
   input  logic thr_wr,
   input  logic thri_flip,
   input  logic thri_new,
   input  logic iir_rd,
   input  logic iir_is_thre,
   input  logic tx_empty_evt,
   input  logic tx_idle_evt,
   output logic thre_pend,
   output logic lsr_thre,
   output logic lsr_temt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lsr_thre <= 1'b1;
         lsr_temt <= 1'b1;
      end else if (thr_wr) begin
         lsr_thre <= 1'b0;
         lsr_temt <= 1'b0;
      end else begin
         if (tx_empty_evt) lsr_thre <= 1'b1;
         if (tx_idle_evt)  lsr_temt <= 1'b1;
      end
   end

   // thr_wr > enable flip > drain event > identification read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     thre_pend <= 1'b0;
      else if (thr_wr)                thre_pend <= 1'b0;
      else if (thri_flip)             thre_pend <= thri_new && lsr_thre;
      else if (tx_empty_evt)          thre_pend <= 1'b1;
      else if (iir_rd && iir_is_thre) thre_pend <= 1'b0;
   end

   // R11
   thr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr |=> !lsr_thre && !lsr_temt && !thre_pend);

   // R9
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd && iir_is_thre && !thr_wr && !thri_flip && !tx_empty_evt) |=> !thre_pend);

   // R13
   drain_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_empty_evt && !thr_wr) |=> lsr_thre);
endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
   import uirq_pkg::*;
#(
   parameter int CNT_W    = 5,
   parameter bit HAS_FIFO = 1'b1
) (
   input  logic [3:0]       ier,
   input  logic [3:0]       lsr_err,
   input  logic             data_ready,
   input  logic             fifo_en,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] rx_trig,
   input  logic             timeout_pend,
   input  logic             thre_pend,
   input  logic [3:0]       msr_delta,
   output iid_e             code
);
   logic                rx_lvl_ok;
   logic [NUM_SRC-1:0]  req;

   generate
      if (HAS_FIFO) begin : g_fifo_cmp
         assign rx_lvl_ok = !fifo_en || (rx_count >= rx_trig);
      end else begin : g_no_fifo
         logic unused_cnt;
         assign unused_cnt = ^{rx_count, rx_trig, fifo_en};
         assign rx_lvl_ok  = 1'b1;
      end
   endgenerate

   assign req[0] = ier[2] && (|lsr_err);
   assign req[1] = ier[0] && timeout_pend;
   assign req[2] = ier[0] && data_ready && rx_lvl_ok;
   assign req[3] = ier[1] && thre_pend;
   assign req[4] = ier[3] && (|msr_delta);

   always_comb begin
      code = IID_NONE;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req[i]) code = src_code(i);
      end
   end
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
   import uirq_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter bit HAS_FIFO   = 1'b1,
   localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ier_wr,
   input  logic [7:0]       ier_wdata,
   input  logic             iir_rd,
   input  logic             thr_wr,
   input  logic             tx_empty_evt,
   input  logic             tx_idle_evt,
   input  logic             fifo_en,
   input  logic [3:0]       lsr_err,
   input  logic             data_ready,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] rx_trig,
   input  logic             timeout_pend,
   input  logic [3:0]       msr_delta,
   output logic [7:0]       ier_o,
   output logic [7:0]       iir_o,
   output logic             irq_o,
   output logic             lsr_thre_o,
   output logic             lsr_temt_o
);
   localparam int IER_BITS = 4;

   generate
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("uirq_ctrl: FIFO_DEPTH must be at least 2");
      end
   endgenerate

   logic [IER_BITS-1:0] ier_q;
   logic                thri_flip;
   logic                thre_pend;
   iid_e                code_nxt;
   logic [3:0]          iid_q;
   logic [1:0]          fifo_tag_q;

   uirq_ier_reg #(.BUS_W(8), .IER_BITS(IER_BITS)) u_ier (
      .clk(clk), .rst_n(rst_n), .wr(ier_wr), .wdata(ier_wdata),
      .ier_q(ier_q), .thri_flip(thri_flip)
   );

   uirq_thre_track u_thre (
      .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr),
      .thri_flip(thri_flip), .thri_new(ier_wdata[1]),
      .iir_rd(iir_rd), .iir_is_thre(iid_q == IID_THRE),
      .tx_empty_evt(tx_empty_evt), .tx_idle_evt(tx_idle_evt),
      .thre_pend(thre_pend), .lsr_thre(lsr_thre_o), .lsr_temt(lsr_temt_o)
   );

   uirq_prio_enc #(.CNT_W(CNT_W), .HAS_FIFO(HAS_FIFO)) u_enc (
      .ier(ier_q), .lsr_err(lsr_err), .data_ready(data_ready),
      .fifo_en(fifo_en), .rx_count(rx_count), .rx_trig(rx_trig),
      .timeout_pend(timeout_pend), .thre_pend(thre_pend),
      .msr_delta(msr_delta), .code(code_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iid_q      <= IID_NONE;
         fifo_tag_q <= 2'b00;
         irq_o      <= 1'b0;
      end else begin
         iid_q      <= code_nxt;
         fifo_tag_q <= {2{fifo_en}};
         irq_o      <= (code_nxt != IID_NONE);
      end
   end

   assign iir_o = {fifo_tag_q, 2'b00, iid_q};
   assign ier_o = {{(8 - IER_BITS){1'b0}}, ier_q};

   // R8
   irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == !iir_o[0]);

   // R2
   line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_q[2] && (|lsr_err)) |=> iir_o[3:0] == 4'h6);

   // R6
   code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iir_o[3:0] inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h6, 4'hC});

   // R7
   fifo_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> iir_o[7:6] == {2{$past(fifo_en)}} && iir_o[5:4] == 2'b00);
endmodule

// File: tb/uirq_ctrl_tb_top.sv
`timescale 1ns/100ps
module uirq_ctrl_tb_top;
   localparam int DEPTH = 16;
   localparam int CW    = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ier_wr = 0, iir_rd = 0, thr_wr = 0, tx_empty_evt = 0, tx_idle_evt = 0;
   logic [7:0] ier_wdata = '0;
   logic fifo_en = 0, data_ready = 0, timeout_pend = 0;
   logic [3:0] lsr_err = '0, msr_delta = '0;
   logic [CW-1:0] rx_count = '0, rx_trig = '0;
   logic [7:0] ier_o, iir_o;
   logic irq_o, lsr_thre_o, lsr_temt_o;

   always #2.5 clk = ~clk;

   uirq_ctrl #(.FIFO_DEPTH(DEPTH), .HAS_FIFO(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
      .iir_rd(iir_rd), .thr_wr(thr_wr), .tx_empty_evt(tx_empty_evt),
      .tx_idle_evt(tx_idle_evt), .fifo_en(fifo_en), .lsr_err(lsr_err),
      .data_ready(data_ready), .rx_count(rx_count), .rx_trig(rx_trig),
      .timeout_pend(timeout_pend), .msr_delta(msr_delta),
      .ier_o(ier_o), .iir_o(iir_o), .irq_o(irq_o),
      .lsr_thre_o(lsr_thre_o), .lsr_temt_o(lsr_temt_o)
   );

   typedef struct {
      string      tag;
      logic [7:0] iir;
      logic       irq;
      logic [7:0] ier;
      logic       thre;
      logic       temt;
   } exp_t;

   exp_t sb_q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   logic [7:0] e_ier = 8'h00;
   logic e_thre = 1'b1, e_temt = 1'b1;
   bit   done = 0;

   task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
      end
   endtask

   // monitor: compare at the falling edge
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         cmp(e.tag, "iir",  iir_o, e.iir);
         cmp(e.tag, "irq",  {7'b0, irq_o}, {7'b0, e.irq});
         cmp(e.tag, "ier",  ier_o, e.ier);
         cmp(e.tag, "thre", {7'b0, lsr_thre_o}, {7'b0, e.thre});
         cmp(e.tag, "temt", {7'b0, lsr_temt_o}, {7'b0, e.temt});
      end
   end

   task automatic expect_iir(string tag, logic [7:0] iir);
      exp_t e;
      e.tag = tag; e.iir = iir; e.irq = ~iir[0];
      e.ier = e_ier; e.thre = e_thre; e.temt = e_temt;
      sb_q.push_back(e);
   endtask

   task automatic settle(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr_ier(logic [7:0] d);
      @(negedge clk); ier_wr = 1; ier_wdata = d;
      @(posedge clk); #1; ier_wr = 0;
      e_ier = {4'h0, d[3:0]};
   endtask

   task automatic rd_iir();
      @(negedge clk); iir_rd = 1;
      @(posedge clk); #1; iir_rd = 0;
   endtask

   task automatic pulse_thr();
      @(negedge clk); thr_wr = 1;
      @(posedge clk); #1; thr_wr = 0;
      e_thre = 0; e_temt = 0;
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      settle(1);
      expect_iir("R1 reset", 8'h01);

      // R12: upper write bits dropped; R10: bit1 flip with THRE=1 arms flag
      wr_ier(8'hFF);
      settle(1);
      expect_iir("R12 R10 R5 R8 enable all", 8'h02);

      // R9: read while showing THR empty clears it
      rd_iir(); settle(1);
      expect_iir("R9 read clears", 8'h01);

      // R6 modem cause
      @(negedge clk); msr_delta = 4'b0001; settle(1);
      expect_iir("R6 modem", 8'h00);

      // R7 FIFO tag
      @(negedge clk); fifo_en = 1; settle(1);
      expect_iir("R7 fifo tag", 8'hC0);

      // R4 below trigger: nothing new
      @(negedge clk); data_ready = 1; rx_trig = 5'd4; rx_count = 5'd3; settle(1);
      expect_iir("R4 below trigger", 8'hC0);
      @(negedge clk); rx_count = 5'd4; settle(1);
      expect_iir("R4 at trigger", 8'hC4);

      // R3 timeout above rx data
      @(negedge clk); timeout_pend = 1; settle(1);
      expect_iir("R3 timeout", 8'hCC);

      // R3 masked by bit0; R10 bit1 unchanged leaves flag clear
      wr_ier(8'h0E); settle(1);
      expect_iir("R3 R10 masked by rx enable", 8'hC0);

      // R2 line status outranks
      @(negedge clk); lsr_err = 4'b0100; settle(1);
      expect_iir("R2 line error", 8'hC6);
      wr_ier(8'h0A); settle(1);
      expect_iir("R2 masked", 8'hC0);

      @(negedge clk); lsr_err = 0; msr_delta = 0; timeout_pend = 0; data_ready = 0;
      settle(1);
      expect_iir("R6 none", 8'hC1);

      // R11 holding write
      pulse_thr();
      expect_iir("R11 thr write", 8'hC1);

      // R13 drain and idle
      @(negedge clk); tx_empty_evt = 1;
      @(posedge clk); #1; tx_empty_evt = 0;
      e_thre = 1;
      settle(1);
      expect_iir("R13 drain", 8'hC2);
      @(negedge clk); tx_idle_evt = 1;
      @(posedge clk); #1; tx_idle_evt = 0;
      e_temt = 1;
      expect_iir("R13 idle", 8'hC2);

      // R9 read while another code shown leaves flag
      @(negedge clk); fifo_en = 0; data_ready = 1;
      wr_ier(8'h0B); settle(1);
      expect_iir("R4 no fifo", 8'h04);
      rd_iir(); settle(1);
      expect_iir("R9 other read", 8'h04);
      @(negedge clk); data_ready = 0; settle(1);
      expect_iir("R9 flag kept", 8'h02);

      // R10 toggles
      wr_ier(8'h08); settle(1);
      expect_iir("R10 disable clears", 8'h01);
      wr_ier(8'h0A); settle(1);
      expect_iir("R10 enable rearms", 8'h02);
      pulse_thr(); settle(1);
      expect_iir("R11 clears pending", 8'h01);
      wr_ier(8'h08);
      wr_ier(8'h0A); settle(1);
      expect_iir("R10 no arm when full", 8'h01);

      settle(2);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule